// File: doc/BRIEF.md
# Line-Rate Sync Flywheel and Back-Porch Gate

This block sits behind a digital slicer. It takes an active-low composite sync level, sampled on the system clock, and rebuilds a clean horizontal timing reference from it. A line counter tracks the expected line period and opens an acceptance window around the point where the next line should begin. Only a leading (falling) sync edge that lands inside that window restarts the line. Half-line equalizing pulses, the serrated broad pulses of the vertical interval and isolated noise pulses fall outside the window, so they cannot add horizontal pulses. If the window closes without an edge, the counter fires a substitute line start and keeps the line grid running.

Each line start arms a back-porch gate. The back-porch pulse fires once per line, on the first trailing (rising) sync edge after the line start or on an arm timeout when the sync stays low too long. A separate missed-sync timer raises a flag after roughly one and a half lines without any leading edge. While that flag is high, the next leading edge is accepted at any phase, which lets the block lock again after a dropout or a phase jump. Every delay and width is a parameter in clock cycles, so one netlist covers line rates from 15 kHz to 130 kHz.

Top module: `line_sync_gen`

## Requirements
- R1: While rst_ni is low and directly after it is released, hsync_no and bporch_no are 1, bp_en_o is 0 and nosync_o is 1.
- R2: Let t be the clock edge at which csync_ni is first sampled 0 after being sampled 1. If that leading edge is accepted, hsync_no is 0 from edge t+1+HS_DLY_CYC for exactly HS_WID_CYC cycles.
- R3: While nosync_o is 0, a leading edge is accepted only if it is sampled between LINE_CYC-WIN_CYC and LINE_CYC+WIN_CYC cycles after the previous line start, bounds included. Any other leading edge produces no horizontal pulse, no back-porch pulse and no line restart.
- R4: If no edge is accepted by LINE_CYC+WIN_CYC cycles after a line start, a substitute line start occurs at that cycle. The horizontal and back-porch pulses follow it with the usual delays. Substitute starts repeat every LINE_CYC cycles while no edge is accepted.
- R5: nosync_o rises at edge t+NOSYNC_CYC+2 when no leading edge has been sampled since the one at edge t. It falls at edge t+1 after any sampled leading edge.
- R6: While nosync_o is 1, a leading edge is accepted at any phase and restarts the line grid from that edge.
- R7: bp_en_o rises at edge t+1 after a line start at edge t. It stays 1 until the back-porch pulse is triggered and falls on the edge after the trigger.
- R8: If, while bp_en_o is 1, csync_ni is first sampled 1 at edge u with u-t below ARM_CYC, then bporch_no is 0 from edge u+1+BP_DLY_CYC for exactly BP_WID_CYC cycles.
- R9: If no trailing edge arrives within ARM_CYC cycles of a line start at edge t, bporch_no is 0 from edge t+1+ARM_CYC+BP_DLY_CYC for BP_WID_CYC cycles.
- R10: Across equalizing lines (two short pulses per line), broad-pulse lines (two long pulses per line) and mid-line noise pulses, exactly one horizontal pulse and one back-porch pulse appear per line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csync_ni | input | 1 | Sliced composite sync, active low |
| hsync_no | output | 1 | Regenerated horizontal sync, active low |
| bporch_no | output | 1 | Gated back-porch pulse, active low |
| bp_en_o | output | 1 | Back-porch gate armed for the current line |
| nosync_o | output | 1 | Missed-sync flag |

## Verification
The bench builds the block with a 64-cycle line, a window of ±4 cycles, horizontal delay and width of 1 and 8 cycles, back-porch delay and width of 2 and 6 cycles, an arm timeout of 16 cycles and a missed-sync limit of 96 cycles. With lines this short, a full vertical interval of equalizing and broad pulses, a single dropped line, a multi-line dropout with a phase jump, and edges at both window limits all fit in a few thousand cycles. Every pulse time is then predicted arithmetically from the cycle at which each line was driven. The broad pulses are longer than the arm timeout, so the timeout path of the back-porch gate is exercised on every broad line.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

  typedef struct packed {
    logic fall;
    logic rise;
  } sync_edge_t;

  function automatic int unsigned cnt_w(input int unsigned max_v);
    return (max_v < 1) ? 1 : $clog2(max_v + 1);
  endfunction

endpackage

// File: rtl/lsg_edge.sv
module lsg_edge
  import lsg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_ni,
  output sync_edge_t edg_o
);

  logic smp_q, dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= 1'b1;
      dly_q <= 1'b1;
    end else begin
      smp_q <= sync_ni;
      dly_q <= smp_q;
    end
  end

  assign edg_o.fall = dly_q & ~smp_q;
  assign edg_o.rise = ~dly_q & smp_q;

endmodule

// File: rtl/lsg_line_win.sv
module lsg_line_win
  import lsg_pkg::*;
#(
  parameter int unsigned LINE_CYC   = 1716,
  parameter int unsigned WIN_CYC    = 53,
  parameter int unsigned NOSYNC_CYC = 2574
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic line_evt_o,
  output logic nosync_o
);

  localparam int unsigned HI = LINE_CYC + WIN_CYC;
  localparam int unsigned LO = LINE_CYC - WIN_CYC;
  localparam int unsigned CW = cnt_w(HI);
  localparam int unsigned NW = cnt_w(NOSYNC_CYC);
  localparam logic [CW-1:0] HI_C      = CW'(HI);
  localparam logic [CW-1:0] LO_C      = CW'(LO);
  localparam logic [CW-1:0] RESTART_C = CW'(WIN_CYC + 1);
  localparam logic [CW-1:0] ONE_C     = CW'(1);
  localparam logic [NW-1:0] NS_C      = NW'(NOSYNC_CYC);
  localparam logic [NW-1:0] NS_ONE_C  = NW'(1);

  logic [CW-1:0] cnt_q;
  logic [NW-1:0] ns_q;
  logic          nosync_q;
  logic          in_win, acc, fly;

  assign in_win     = (cnt_q >= LO_C) && (cnt_q <= HI_C);
  assign acc        = fall_i && (nosync_q || in_win);
  // window closed with nothing accepted: keep the grid running
  assign fly        = !acc && (cnt_q == HI_C);
  assign line_evt_o = acc || fly;
  assign nosync_o   = nosync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (acc) begin
      cnt_q <= ONE_C;
    end else if (fly) begin
      // restart as if the edge had come on the nominal line start
      cnt_q <= RESTART_C;
    end else begin
      cnt_q <= cnt_q + ONE_C;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q     <= '0;
      nosync_q <= 1'b1;
    end else if (fall_i) begin
      ns_q     <= '0;
      nosync_q <= 1'b0;
    end else if (ns_q == NS_C) begin
      nosync_q <= 1'b1;
    end else begin
      ns_q <= ns_q + NS_ONE_C;
    end
  end

  // R5
  nosync_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> !nosync_o);

  // R4
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_evt_o |=> (cnt_q <= RESTART_C));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HI_C);

endmodule

// File: rtl/lsg_bp_gate.sv
module lsg_bp_gate
  import lsg_pkg::*;
#(
  parameter int unsigned ARM_CYC = 286
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_evt_i,
  input  logic rise_i,
  output logic en_o,
  output logic trig_o
);

  localparam int unsigned AW = cnt_w(ARM_CYC);
  localparam logic [AW-1:0] ARM_C = AW'(ARM_CYC);
  localparam logic [AW-1:0] ONE_C = AW'(1);

  logic          armed_q;
  logic [AW-1:0] arm_cnt_q;

  assign trig_o = armed_q && (rise_i || (arm_cnt_q == ARM_C));
  assign en_o   = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      arm_cnt_q <= '0;
    end else if (line_evt_i) begin
      armed_q   <= 1'b1;
      arm_cnt_q <= ONE_C;
    end else if (trig_o) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      arm_cnt_q <= arm_cnt_q + ONE_C;
    end
  end

  // R7
  arm_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_q) |-> $past(trig_o));

  // R9
  arm_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (arm_cnt_q <= ARM_C));

endmodule

// File: rtl/lsg_pulse.sv
module lsg_pulse
  import lsg_pkg::*;
#(
  parameter int unsigned DLY_CYC = 5,
  parameter int unsigned WID_CYC = 187
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic act_o
);

  localparam int unsigned END_V = DLY_CYC + WID_CYC;
  localparam int unsigned CW    = cnt_w(END_V);
  localparam logic [CW-1:0] END_C = CW'(END_V);
  localparam logic [CW-1:0] DLY_C = CW'(DLY_CYC);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i) begin
      busy_q <= 1'b1;
      cnt_q  <= ONE_C;
    end else if (busy_q) begin
      if (cnt_q == END_C) busy_q <= 1'b0;
      else                cnt_q  <= cnt_q + ONE_C;
    end
  end

  assign act_o = busy_q && (cnt_q > DLY_C) && (cnt_q <= END_C);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !trig_i) |=> !act_o);

endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen
  import lsg_pkg::*;
#(
  parameter int unsigned LINE_CYC   = 1716,
  parameter int unsigned WIN_CYC    = LINE_CYC / 32,
  parameter int unsigned HS_DLY_CYC = LINE_CYC / 330,
  parameter int unsigned HS_WID_CYC = (LINE_CYC * 7) / 64,
  parameter int unsigned BP_DLY_CYC = LINE_CYC / 127,
  parameter int unsigned BP_WID_CYC = (LINE_CYC * 5) / 127,
  parameter int unsigned ARM_CYC    = LINE_CYC / 6,
  parameter int unsigned NOSYNC_CYC = (LINE_CYC * 3) / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_ni,
  output logic hsync_no,
  output logic bporch_no,
  output logic bp_en_o,
  output logic nosync_o
);

  sync_edge_t edg;
  logic       line_evt, bp_trig, hs_act, bp_act;

  lsg_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_ni(csync_ni),
    .edg_o  (edg)
  );

  lsg_line_win #(
    .LINE_CYC  (LINE_CYC),
    .WIN_CYC   (WIN_CYC),
    .NOSYNC_CYC(NOSYNC_CYC)
  ) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (edg.fall),
    .line_evt_o(line_evt),
    .nosync_o  (nosync_o)
  );

  lsg_bp_gate #(
    .ARM_CYC(ARM_CYC)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_evt_i(line_evt),
    .rise_i    (edg.rise),
    .en_o      (bp_en_o),
    .trig_o    (bp_trig)
  );

  lsg_pulse #(
    .DLY_CYC(HS_DLY_CYC),
    .WID_CYC(HS_WID_CYC)
  ) u_hs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(line_evt),
    .act_o (hs_act)
  );

  lsg_pulse #(
    .DLY_CYC(BP_DLY_CYC),
    .WID_CYC(BP_WID_CYC)
  ) u_bp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(bp_trig),
    .act_o (bp_act)
  );

  assign hsync_no  = ~hs_act;
  assign bporch_no = ~bp_act;

  // R7
  arm_on_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_evt |=> bp_en_o);

endmodule

// File: tb/line_sync_gen_tb_top.sv
module line_sync_gen_tb_top;

  localparam int L   = 64;
  localparam int W   = 4;
  localparam int HD  = 1;
  localparam int HW  = 8;
  localparam int BD  = 2;
  localparam int BW  = 6;
  localparam int ARM = 16;
  localparam int NS  = 96;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic csync_ni = 1'b1;
  logic hsync_no, bporch_no, bp_en_o, nosync_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int last_acc = 0;
  int last_fall = 0;

  int    exp_hs[$];
  string tag_hs[$];
  int    exp_bp[$];
  string tag_bp[$];
  int    act_hs[$];
  int    act_bp[$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  line_sync_gen #(
    .LINE_CYC(L), .WIN_CYC(W), .HS_DLY_CYC(HD), .HS_WID_CYC(HW),
    .BP_DLY_CYC(BD), .BP_WID_CYC(BW), .ARM_CYC(ARM), .NOSYNC_CYC(NS)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .csync_ni(csync_ni),
    .hsync_no(hsync_no), .bporch_no(bporch_no),
    .bp_en_o(bp_en_o), .nosync_o(nosync_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 normal, 1 normal with mid-line noise, 2 equalizing, 3 broad
  function automatic logic lvl(input int kind, input int k);
    case (kind)
      0:       return !(k < 5);
      1:       return !(k < 5 || (k >= 30 && k < 32));
      2:       return !(k < 2 || (k >= 32 && k < 34));
      3:       return !(k < 27 || (k >= 32 && k < 59));
      default: return 1'b1;
    endcase
  endfunction

  function automatic int rise_off(input int kind);
    case (kind)
      2:       return 2;
      3:       return 27;
      default: return 5;
    endcase
  endfunction

  task automatic run_line(input int kind, input int len, input string tag, input bit clr_chk);
    int n0 = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk_i);
      if (k == 0) begin
        n0 = cyc;
        last_acc = n0;
        exp_hs.push_back(n0 + 2 + HD);
        tag_hs.push_back(tag);
        if (rise_off(kind) < ARM) begin
          exp_bp.push_back(n0 + rise_off(kind) + 2 + BD);
          tag_bp.push_back("R8");
        end else begin
          exp_bp.push_back(n0 + 2 + ARM + BD);
          tag_bp.push_back("R9");
        end
      end
      if (clr_chk && k == 1) check(nosync_o == 1'b1, "R5 flag before clear", nosync_o, 1);
      if (clr_chk && k == 2) check(nosync_o == 1'b0, "R5 flag cleared", nosync_o, 0);
      if (kind == 0 && k == 6) check(bp_en_o == 1'b1, "R7 armed", bp_en_o, 1);
      if (kind == 0 && k == 7) check(bp_en_o == 1'b0, "R7 disarmed", bp_en_o, 0);
      if (kind == 3 && k == 17) check(bp_en_o == 1'b1, "R9 armed to timeout", bp_en_o, 1);
      if (kind == 3 && k == 18) check(bp_en_o == 1'b0, "R9 disarmed at timeout", bp_en_o, 0);
      csync_ni = lvl(kind, k);
    end
    case (kind)
      1:       last_fall = n0 + 30;
      2, 3:    last_fall = n0 + 32;
      default: last_fall = n0;
    endcase
  endtask

  task automatic run_silent(input int len);
    int s = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk_i);
      if (k == 0) s = cyc;
      if (cyc == last_fall + NS + 2) check(nosync_o == 1'b0, "R5 flag not yet", nosync_o, 0);
      if (cyc == last_fall + NS + 3) check(nosync_o == 1'b1, "R5 flag raised", nosync_o, 1);
      csync_ni = 1'b1;
    end
    for (int x = last_acc + 1 + L + W; x < s + len + 1; x += L) begin
      exp_hs.push_back(x + 1 + HD);
      tag_hs.push_back("R4");
      exp_bp.push_back(x + ARM + 1 + BD);
      tag_bp.push_back("R4");
    end
  endtask

  int   hs_lo = 0, bp_lo = 0;
  logic hs_p = 1'b1, bp_p = 1'b1;

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (hs_p && !hsync_no) begin
        act_hs.push_back(cyc);
        hs_lo = cyc;
      end
      if (!hs_p && hsync_no) check(cyc - hs_lo == HW, "R2 hsync width", cyc - hs_lo, HW);
      if (bp_p && !bporch_no) begin
        act_bp.push_back(cyc);
        bp_lo = cyc;
      end
      if (!bp_p && bporch_no) check(cyc - bp_lo == BW, "R8 back-porch width", cyc - bp_lo, BW);
      hs_p = hsync_no;
      bp_p = bporch_no;
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    // R1 outputs held during reset
    check(hsync_no == 1'b1 && bporch_no == 1'b1, "R1 pulses idle in reset", {hsync_no, bporch_no}, 3);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(hsync_no == 1'b1, "R1 hsync idle", hsync_no, 1);
    check(bporch_no == 1'b1, "R1 back porch idle", bporch_no, 1);
    check(bp_en_o == 1'b0, "R1 gate disarmed", bp_en_o, 0);
    check(nosync_o == 1'b1, "R1 flag set", nosync_o, 1);

    run_line(0, L, "R6", 1'b1);
    run_line(0, L, "R2", 1'b0);
    run_line(0, L - W, "R2", 1'b0);
    run_line(0, L + W, "R3", 1'b0);
    run_line(0, L, "R3", 1'b0);
    run_line(1, L, "R2", 1'b0);
    run_line(0, L, "R3", 1'b0);
    for (int i = 0; i < 3; i++) run_line(2, L, "R10", 1'b0);
    for (int i = 0; i < 3; i++) run_line(3, L, "R10", 1'b0);
    for (int i = 0; i < 3; i++) run_line(2, L, "R10", 1'b0);
    run_line(0, L, "R10", 1'b0);
    run_line(0, L, "R2", 1'b0);
    run_silent(L);
    run_line(0, L, "R6", 1'b1);
    run_line(0, L, "R2", 1'b0);
    run_silent(3 * L + 30);
    run_line(0, L, "R6", 1'b1);
    run_line(0, L, "R3", 1'b0);
    run_line(0, L, "R2", 1'b0);

    finished = 1;
    check(act_hs.size() == exp_hs.size(), "R10 horizontal pulse count", act_hs.size(), exp_hs.size());
    check(act_bp.size() == exp_bp.size(), "R10 back-porch pulse count", act_bp.size(), exp_bp.size());
    for (int i = 0; i < exp_hs.size() && i < act_hs.size(); i++)
      check(act_hs[i] == exp_hs[i], {tag_hs[i], " hsync start"}, act_hs[i], exp_hs[i]);
    for (int i = 0; i < exp_bp.size() && i < act_bp.size(); i++)
      check(act_bp[i] == exp_bp[i], {tag_bp[i], " back-porch start"}, act_bp[i], exp_bp[i]);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

endmodule